// File: doc/BRIEF.md
# Predicate-Result Element Write Gate

This block decides, element by element, what a vector arithmetic operation writes back. After a start pulse it walks the element index from 0 to VL-1, one element per cycle. For each element the surrounding datapath supplies the predicate bit and the 4-bit condition field computed from that element's result. The block then says whether to store the condition field, whether to store the result, whether to write zero to the destination instead, and whether the source operand should read as zero.

A condition test gates the result store. A control selects one bit of the condition field, and an invert flag says which polarity counts as a pass. A failing element behaves as though its destination predicate bit had been clear. Its condition field is still stored when condition writing is on, so software can find out afterwards which elements failed. In compare-only mode the operation acts like a compare: condition fields are written and results never are. One zeroing flag covers both source and destination zeroing.

The operation controls are captured when a start is accepted. The per-element decisions come out registered, one cycle after the element's inputs are sampled. A one-cycle done pulse marks the end of the vector.

Top module: `predres_wgate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `out_valid`, `done`, `wr_cond`, `wr_res`, `wr_zero` and `src_zero` are all 0.
- R2: A `start` seen while idle captures `vl` and the controls (`rc_en`, `cmp_only`, `bit_sel`, `bit_inv`, `zero_en`). If `vl` is nonzero, `busy` rises the next cycle and `elem_idx` steps 0,1,…,vl-1 at one element per cycle, after which `busy` falls. A `start` while busy, and any change to the controls during a run, has no effect.
- R3: The decision for the element shown on `elem_idx` appears one cycle later with `out_valid`=1 and `out_idx` equal to that index. When `out_valid`=0, all four write outputs are 0.
- R4: An element whose `elem_pred` is 0 writes neither its condition field nor its result.
- R5: An element with `elem_pred`=1 writes its condition field whenever `rc_en` or `cmp_only` is set, whether the test passes or fails.
- R6: The test passes when `elem_cond[bit_sel]` differs from `bit_inv`, where `bit_sel` indexes bit 0..3 of the field. An element with `elem_pred`=1 writes its result only when the test passes and `cmp_only`=0.
- R7: With `cmp_only`=1, no element writes a result or a destination zero.
- R8: With `zero_en`=1 and `cmp_only`=0, `wr_zero` is 1 for elements that are masked out or that fail the test. `wr_res` and `wr_zero` are never both 1.
- R9: `src_zero` is 1 exactly for valid elements with `elem_pred`=0 while `zero_en`=1, in every mode.
- R10: `done` is a one-cycle pulse in the same cycle as the output of element vl-1.
- R11: A start accepted with `vl`=0 produces no element outputs and raises `done` in the next cycle, with `busy` staying 0.
- R12: With `rc_en`=0 and `cmp_only`=0, no condition field is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector operation (accepted only when idle) |
| vl | input | 7 | Vector length, 0 to MAX_VL |
| rc_en | input | 1 | Store condition fields |
| cmp_only | input | 1 | Compare-only: store condition fields, never results |
| bit_sel | input | 2 | Index of the tested condition bit |
| bit_inv | input | 1 | Polarity: the test passes when the selected bit differs from this |
| zero_en | input | 1 | Zeroing for both source and destination |
| elem_pred | input | 1 | Predicate bit of the current element |
| elem_cond | input | 4 | Condition field of the current element's result |
| busy | output | 1 | An element is being presented this cycle |
| elem_idx | output | 6 | Index of the element being presented |
| out_valid | output | 1 | Registered decision valid |
| out_idx | output | 6 | Index the decision belongs to |
| wr_cond | output | 1 | Store the condition field |
| wr_res | output | 1 | Store the result |
| wr_zero | output | 1 | Store zero in the destination |
| src_zero | output | 1 | Treat the source operand as zero |
| done | output | 1 | One-cycle end-of-vector pulse |

## Verification
Two things the block reports can land in the same cycle. The decision for the final element comes out in the cycle `done` pulses, and a stored condition field can come out together with a cancelled result store. The scoreboard marks the last expected item of each run as carrying `done`, so a pulse that arrives one cycle early or late is caught as a field mismatch on that item. Runs with condition writing on, and with data that makes some elements fail the test, produce cycles where `wr_cond`=1 and `wr_res`=0; each such cycle is checked against the independently computed pass/fail result.

// File: rtl/predres_pkg.sv
package predres_pkg;
  localparam int COND_W = 4;
  localparam int SEL_W  = $clog2(COND_W);

  typedef struct packed {
    logic             rc;
    logic             cmp;
    logic [SEL_W-1:0] sel;
    logic             inv;
    logic             zero;
  } ctl_t;

  typedef struct packed {
    logic cond;
    logic res;
    logic zero;
    logic src;
  } wr_t;
endpackage

// File: rtl/predres_seq.sv
module predres_seq #(
  parameter int MAX_VL = 64,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = $clog2(MAX_VL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  output logic            accept,
  output logic            busy,
  output logic            last,
  output logic            empty_done,
  output logic [IDXW-1:0] idx
);
  logic            busy_q, busy_n;
  logic [IDXW-1:0] cnt_q, cnt_n;
  logic [VLW-1:0]  vl_q, vl_n;
  logic            cnt_en;

  assign accept     = start && !busy_q;
  assign empty_done = accept && (vl == '0);
  assign last       = busy_q && ((VLW'(cnt_q) + VLW'(1)) == vl_q);

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    vl_n   = vl_q;
    cnt_en = 1'b0;
    if (accept) begin
      cnt_en = 1'b1;
      busy_n = (vl != '0);
      cnt_n  = '0;
      vl_n   = vl;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (last) busy_n = 1'b0;
      else      cnt_n  = cnt_q + IDXW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vl_q   <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      vl_q   <= vl_n;
    end
  end

  assign busy = busy_q;
  assign idx  = cnt_q;

  // R2
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (VLW'(cnt_q) < vl_q));
  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !last) |=> (busy_q && cnt_q == $past(cnt_q) + IDXW'(1)));
  // R11
  empty_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_done |=> !busy_q);
endmodule

// File: rtl/predres_decide.sv
module predres_decide
  import predres_pkg::*;
(
  input  ctl_t              ctl,
  input  logic              pred,
  input  logic [COND_W-1:0] cond,
  output wr_t               wr
);
  logic pass;
  logic keep;

  assign pass = cond[ctl.sel] ^ ctl.inv;
  assign keep = pred && pass && !ctl.cmp;

  always_comb begin
    wr.cond = pred && (ctl.rc || ctl.cmp);
    wr.res  = keep;
    wr.zero = ctl.zero && !ctl.cmp && !keep;
    wr.src  = ctl.zero && !pred;
  end
endmodule

// File: rtl/predres_outreg.sv
module predres_outreg
  import predres_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic [IDXW-1:0] in_idx,
  input  wr_t             in_wr,
  input  logic            empty_done,
  output logic            out_valid,
  output logic [IDXW-1:0] out_idx,
  output wr_t             out_wr,
  output logic            done
);
  wr_t  wr_n;
  logic done_n;

  always_comb begin
    wr_n   = in_valid ? in_wr : '0;
    done_n = (in_valid && in_last) || empty_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wr    <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr    <= wr_n;
      done      <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_idx <= '0;
    else if (in_valid) out_idx <= in_idx;
  end

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_wr == '0));
  // R3
  idx_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_idx == $past(in_idx)));
  // R11
  empty_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_done |=> (done && !out_valid));
endmodule

// File: rtl/predres_wgate.sv
module predres_wgate
  import predres_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl,
  input  logic              rc_en,
  input  logic              cmp_only,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              bit_inv,
  input  logic              zero_en,
  input  logic              elem_pred,
  input  logic [COND_W-1:0] elem_cond,
  output logic              busy,
  output logic [IDXW-1:0]   elem_idx,
  output logic              out_valid,
  output logic [IDXW-1:0]   out_idx,
  output logic              wr_cond,
  output logic              wr_res,
  output logic              wr_zero,
  output logic              src_zero,
  output logic              done
);
  logic accept, last, empty_done;
  ctl_t ctl_q, ctl_n;
  wr_t  dec_wr, reg_wr;

  predres_seq #(.MAX_VL(MAX_VL)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .accept(accept), .busy(busy), .last(last),
    .empty_done(empty_done), .idx(elem_idx)
  );

  always_comb begin
    ctl_n.rc   = rc_en;
    ctl_n.cmp  = cmp_only;
    ctl_n.sel  = bit_sel;
    ctl_n.inv  = bit_inv;
    ctl_n.zero = zero_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (accept) ctl_q <= ctl_n;
  end

  predres_decide dec_i (
    .ctl(ctl_q), .pred(elem_pred), .cond(elem_cond), .wr(dec_wr)
  );

  predres_outreg #(.IDXW(IDXW)) oreg_i (
    .clk(clk), .rst_n(rst_n), .in_valid(busy), .in_last(last),
    .in_idx(elem_idx), .in_wr(dec_wr), .empty_done(empty_done),
    .out_valid(out_valid), .out_idx(out_idx), .out_wr(reg_wr), .done(done)
  );

  assign wr_cond  = reg_wr.cond;
  assign wr_res   = reg_wr.res;
  assign wr_zero  = reg_wr.zero;
  assign src_zero = reg_wr.src;

  // R4
  masked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_pred) |=> (out_valid && !wr_cond && !wr_res));
  // R7
  cmp_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_q.cmp) |=> (!wr_res && !wr_zero));
  // R8
  res_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_res && wr_zero));
  // R10
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/predres_wgate_tb.sv
module predres_wgate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [6:0] vl;
  logic       rc_en, cmp_only, bit_inv, zero_en, elem_pred;
  logic [1:0] bit_sel;
  logic [3:0] elem_cond;
  logic       busy, out_valid, wr_cond, wr_res, wr_zero, src_zero, done;
  logic [5:0] elem_idx, out_idx;

  int checks = 0;
  int errors = 0;
  int zero_done_pend = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    int idx;
    bit c, r, z, s, d;
  } exp_t;
  exp_t sb[$];

  predres_wgate #(.MAX_VL(MAX_VL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .rc_en(rc_en),
    .cmp_only(cmp_only), .bit_sel(bit_sel), .bit_inv(bit_inv),
    .zero_en(zero_en), .elem_pred(elem_pred), .elem_cond(elem_cond),
    .busy(busy), .elem_idx(elem_idx), .out_valid(out_valid),
    .out_idx(out_idx), .wr_cond(wr_cond), .wr_res(wr_res),
    .wr_zero(wr_zero), .src_zero(src_zero), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // Driver: presents elements and pushes expected decisions
  task automatic run(input int n, input bit rc, input bit cmp, input bit [1:0] sel,
                     input bit inv, input bit zro, input bit poke);
    @(negedge clk);
    vl = 7'(n); rc_en = rc; cmp_only = cmp; bit_sel = sel; bit_inv = inv; zero_en = zro;
    start = 1'b1;
    if (n == 0) zero_done_pend++;
    @(negedge clk);
    start = 1'b0;
    // controls change after capture; must have no effect (R2)
    rc_en = ~rc; cmp_only = ~cmp; bit_sel = ~sel; bit_inv = ~inv; zero_en = ~zro;
    if (n == 0) begin
      chk(done && !out_valid && !busy, "R11 empty done", {done, out_valid, busy}, 3'b100);
      return;
    end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      bit p, pass;
      step_lfsr();
      p = lfsr[0] | lfsr[5];
      elem_pred = p;
      elem_cond = lfsr[11:8];
      start = poke && (i == 2);
      vl = 7'd1;
      chk(busy && elem_idx == 6'(i), "R2 index walk", {busy, elem_idx}, {1'b1, 6'(i)});
      pass = lfsr[8 + sel] != inv;
      e.idx = i;
      e.c = p && (rc || cmp);
      e.r = p && !cmp && pass;
      e.z = zro && !cmp && (!p || !pass);
      e.s = zro && !p;
      e.d = (i == n - 1);
      sb.push_back(e);
      @(negedge clk);
    end
    start = 1'b0;
    chk(!busy, "R2 busy falls", busy, 0);
  endtask

  // Monitor: pops expectations as decisions appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      if (out_valid) begin
        if (sb.size() == 0) chk(1'b0, "R3 unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(out_idx == 6'(e.idx), "R3 out_idx", out_idx, e.idx);
          chk(wr_cond == e.c, "R4 R5 R12 wr_cond", wr_cond, e.c);
          chk(wr_res == e.r, "R4 R6 R7 wr_res", wr_res, e.r);
          chk(wr_zero == e.z, "R7 R8 wr_zero", wr_zero, e.z);
          chk(src_zero == e.s, "R9 src_zero", src_zero, e.s);
          chk(done == e.d, "R10 done with last", done, e.d);
        end
      end else begin
        if (wr_cond || wr_res || wr_zero || src_zero)
          chk(1'b0, "R3 writes while invalid", {wr_cond, wr_res, wr_zero, src_zero}, 0);
        if (done) begin
          if (zero_done_pend > 0) zero_done_pend--;
          else chk(1'b0, "R10 stray done", 1, 0);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = '0; rc_en = 1'b0; cmp_only = 1'b0;
    bit_sel = '0; bit_inv = 1'b0; zero_en = 1'b0; elem_pred = 1'b0; elem_cond = '0;
    repeat (3) @(negedge clk);
    chk({busy, out_valid, done, wr_cond, wr_res, wr_zero, src_zero} == 0, "R1 in reset",
        {busy, out_valid, done, wr_cond, wr_res, wr_zero, src_zero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, out_valid, done, wr_cond, wr_res, wr_zero, src_zero} == 0, "R1 after reset",
        {busy, out_valid, done, wr_cond, wr_res, wr_zero, src_zero}, 0);

    run(8, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);   // R5 condition kept on failures
    run(8, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0);   // R12 R8 zeroing of failures
    run(6, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1);   // R7 compare-only, R2 start while busy
    run(1, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0);   // R10 single element
    run(0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);   // R11
    run(MAX_VL, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0); // R6 full length
    run(0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0);   // R11 back-to-back
    run(12, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);  // R5 R7 both flags
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3 all decisions seen", sb.size(), 0);
    chk(zero_done_pend == 0, "R11 empty done seen", zero_done_pend, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule